// File: doc/BRIEF.md
# Fast interrupt source selector

This block routes exactly one interrupt source to a dedicated fast interrupt output. It receives three raw level vectors: a basic group of 8 lines and two wide groups of 32 lines each. A single control register on a 32-bit register bus picks one of the 72 lines and carries an enable bit. While the enable bit is set and the index names a real line, the output follows that line's level.

The index space is not ordered by group number. Indices 0 to 31 address the first wide group, 32 to 63 address the second wide group, and 64 to 71 address the basic group. The selector does not read any normal-interrupt mask. A line that is also unmasked on the normal path therefore raises both outputs together. Software has to mask the line on the normal path before it selects the line here.

The output is registered. It shows the selected level one clock after the level is presented.

Top module: `fiq_sel_top`

## Requirements
- R1: After reset the control register reads 0x00000000 at offset 0x0c and fiq_o is 0.
- R2: A write with reg_wr_i=1 and reg_addr_i=0x0c stores reg_wdata_i[7:0] into the control register, where bits 6:0 are the source index and bit 7 is the enable. The stored byte reads back on reg_rdata_o[7:0] whenever reg_addr_i is 0x0c.
- R3: Control bits 31:8 always read as 0, and the values written to them have no effect.
- R4: Writes to any offset other than 0x0c leave the control register unchanged, and reads at any other offset return 0.
- R5: With enable=1 and index 0..31, fiq_o equals src_b1_i[index].
- R6: With enable=1 and index 32..63, fiq_o equals src_b2_i[index-32].
- R7: With enable=1 and index 64..71, fiq_o equals src_b0_i[index-64].
- R8: With enable=0, fiq_o is 0 for any index and any source values.
- R9: With enable=1 and index 72..127, fiq_o is 0.
- R10: fiq_o is registered. It reflects the control register and the source levels as they stood at the previous rising clock edge, and no other line of the source vectors affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| src_b0_i | input | 8 | Basic group source levels |
| src_b1_i | input | 32 | First wide group source levels |
| src_b2_i | input | 32 | Second wide group source levels |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The assertions assume the following about the inputs:
- the source vectors and the bus inputs are synchronous to clk_i;
- the source vectors hold a value across each sampling edge;
- reset is held long enough for the control register to reach zero.

The stimulus changes all inputs only on falling edges, and it holds the source vectors fixed for the two edges that span a control write. The random control words fill all 32 write bits and the full 7-bit index, so out-of-range indices and upper-bit writes both occur. Writes are spread over offset 0x0c and its neighbours.

// File: rtl/fiq_sel_pkg.sv
package fiq_sel_pkg;
  localparam int unsigned IDX_W  = 7;
  localparam int unsigned CTRL_W = IDX_W + 1;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } fiq_ctrl_t;
endpackage

// File: rtl/fiq_ctrl_reg.sv
module fiq_ctrl_reg
  import fiq_sel_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  CTRL_OFS = 8'h0c
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output fiq_ctrl_t         ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic              hit;
  logic              unused_wdata;

  assign hit          = (addr_i == ADDR_W'(CTRL_OFS));
  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_q <= '0;
    else if (wr_i && hit) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = hit ? {{PAD_W{1'b0}}, ctrl_q} : '0;

  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit) |=> ctrl_q == $past(wdata_i[CTRL_W-1:0])); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i || addr_i != ADDR_W'(CTRL_OFS)) |=> $stable(ctrl_q)); // R4
endmodule

// File: rtl/fiq_src_mux.sv
module fiq_src_mux #(
  parameter int unsigned B0_LINES   = 8,
  parameter int unsigned BANK_LINES = 32,
  parameter int unsigned IDX_W      = 7
) (
  input  logic [B0_LINES-1:0]   b0_i,
  input  logic [BANK_LINES-1:0] b1_i,
  input  logic [BANK_LINES-1:0] b2_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic                  level_o,
  output logic                  in_range_o
);
  localparam int unsigned SPAN  = 1 << IDX_W;
  localparam int unsigned N_SRC = 2 * BANK_LINES + B0_LINES;

  logic [SPAN-1:0] flat;

  // index order: wide group one, wide group two, then basic group
  for (genvar g = 0; g < SPAN; g++) begin : g_flat
    if (g < BANK_LINES) begin : g_b1
      assign flat[g] = b1_i[g];
    end else if (g < 2 * BANK_LINES) begin : g_b2
      assign flat[g] = b2_i[g - BANK_LINES];
    end else if (g < N_SRC) begin : g_b0
      assign flat[g] = b0_i[g - 2 * BANK_LINES];
    end else begin : g_pad
      assign flat[g] = 1'b0;
    end
  end

  assign level_o    = flat[idx_i];
  assign in_range_o = (idx_i < IDX_W'(N_SRC));
endmodule

// File: rtl/fiq_out_stage.sv
module fiq_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic in_range_i,
  input  logic level_i,
  output logic fiq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fiq_o <= 1'b0;
    else         fiq_o <= en_i & in_range_i & level_i;
  end
endmodule

// File: rtl/fiq_sel_top.sv
module fiq_sel_top
  import fiq_sel_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned B0_LINES   = 8,
  parameter int unsigned BANK_LINES = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_wr_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic [B0_LINES-1:0]   src_b0_i,
  input  logic [BANK_LINES-1:0] src_b1_i,
  input  logic [BANK_LINES-1:0] src_b2_i,
  output logic                  fiq_o
);
  localparam int unsigned BW    = $clog2(BANK_LINES);
  localparam int unsigned B0W   = $clog2(B0_LINES);
  localparam int unsigned N_SRC = 2 * BANK_LINES + B0_LINES;

  fiq_ctrl_t ctrl;
  logic      level;
  logic      in_range;

  fiq_ctrl_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .ctrl_o(ctrl), .rdata_o(reg_rdata_o)
  );

  fiq_src_mux #(.B0_LINES(B0_LINES), .BANK_LINES(BANK_LINES), .IDX_W(IDX_W)) u_mux (
    .b0_i(src_b0_i), .b1_i(src_b1_i), .b2_i(src_b2_i),
    .idx_i(ctrl.idx), .level_o(level), .in_range_o(in_range)
  );

  fiq_out_stage u_out (
    .clk_i, .rst_ni, .en_i(ctrl.en), .in_range_i(in_range),
    .level_i(level), .fiq_o
  );

  AST_B1_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.en && ctrl.idx < IDX_W'(BANK_LINES))
      |=> fiq_o == $past(src_b1_i[ctrl.idx[BW-1:0]])); // R5
  AST_B2_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.en && ctrl.idx >= IDX_W'(BANK_LINES) && ctrl.idx < IDX_W'(2 * BANK_LINES))
      |=> fiq_o == $past(src_b2_i[ctrl.idx[BW-1:0]])); // R6
  AST_B0_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.en && ctrl.idx >= IDX_W'(2 * BANK_LINES) && ctrl.idx < IDX_W'(N_SRC))
      |=> fiq_o == $past(src_b0_i[ctrl.idx[B0W-1:0]])); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |=> !fiq_o); // R8
  AST_RANGE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.idx >= IDX_W'(N_SRC)) |=> !fiq_o); // R9
endmodule

// File: tb/fiq_sel_top_tb.sv
`timescale 1ns/1ps
module fiq_sel_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = 8'h0c;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  b0 = '0;
  logic [31:0] b1 = '0, b2 = '0;
  logic        fiq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m_ctrl = 8'h00;

  always #2.5 clk = ~clk;

  fiq_sel_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_b0_i(b0),
    .src_b1_i(b1), .src_b2_i(b2), .fiq_o(fiq)
  );

  function automatic logic exp_fiq(logic [7:0] c, logic [7:0] s0, logic [31:0] s1, logic [31:0] s2);
    int i = int'(c[6:0]);
    if (!c[7]) return 1'b0;
    if (i < 32) return s1[i];
    if (i < 64) return s2[i-32];
    if (i < 72) return s0[i-64];
    return 1'b0;
  endfunction

  function automatic string tag_of(logic [7:0] c);
    if (!c[7]) return "R8";
    if (c[6:0] < 32) return "R5";
    if (c[6:0] < 64) return "R6";
    if (c[6:0] < 72) return "R7";
    return "R9";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // drive one bus cycle plus sources, then wait until fiq reflects both
  task automatic step(logic w, logic [7:0] a, logic [31:0] d,
                      logic [7:0] s0, logic [31:0] s1, logic [31:0] s2);
    @(negedge clk);
    wr = w; addr = a; wdata = d; b0 = s0; b1 = s1; b2 = s2;
    if (w && a == 8'h0c) m_ctrl = d[7:0];
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; addr = 8'h0c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all();
    chk({tag_of(m_ctrl), " fiq"}, {31'b0, fiq}, {31'b0, exp_fiq(m_ctrl, b0, b1, b2)});
    chk("R2 readback", rdata, {24'b0, m_ctrl});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    b0 = 8'hff; b1 = '1; b2 = '1;
    repeat (3) @(negedge clk);
    chk("R1 fiq in reset", {31'b0, fiq}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 reset readback", rdata, 32'h0);
    chk("R1 reset fiq", {31'b0, fiq}, 32'h0);

    // R3: upper bits written, read as zero
    step(1'b1, 8'h0c, 32'hdead_be85, 8'h00, 32'h0000_0020, 32'h0);
    chk("R3 upper bits", rdata, 32'h0000_0085);
    chk("R5 idx5", {31'b0, fiq}, 32'h1);

    // R4: other offsets ignored and read zero
    step(1'b1, 8'h08, 32'h0000_00c1, 8'h00, 32'h0000_0020, 32'h0);
    chk("R4 no write", rdata, 32'h0000_0085);
    addr = 8'h10; #1;
    chk("R4 other read", rdata, 32'h0);
    addr = 8'h0c;

    // R6 boundary idx 32 and 63
    step(1'b1, 8'h0c, 32'h0000_00a0, 8'h00, 32'hffff_ffff, 32'h0000_0001);
    chk("R6 idx32", {31'b0, fiq}, 32'h1);
    step(1'b1, 8'h0c, 32'h0000_00bf, 8'hff, 32'hffff_ffff, 32'h7fff_ffff);
    chk("R6 idx63", {31'b0, fiq}, 32'h0);

    // R7 boundaries idx 64, 71
    step(1'b1, 8'h0c, 32'h0000_00c0, 8'h01, 32'h0, 32'h0);
    chk("R7 idx64", {31'b0, fiq}, 32'h1);
    step(1'b1, 8'h0c, 32'h0000_00c7, 8'h7f, 32'hffff_ffff, 32'hffff_ffff);
    chk("R7 idx71", {31'b0, fiq}, 32'h0);

    // R9 idx 72 with all sources high
    step(1'b1, 8'h0c, 32'h0000_00c8, 8'hff, 32'hffff_ffff, 32'hffff_ffff);
    chk("R9 idx72", {31'b0, fiq}, 32'h0);

    // R8 enable clear
    step(1'b1, 8'h0c, 32'h0000_0003, 8'hff, 32'hffff_ffff, 32'hffff_ffff);
    chk("R8 disabled", {31'b0, fiq}, 32'h0);

    // R10: one-cycle latency on a source change, idx 31
    step(1'b1, 8'h0c, 32'h0000_009f, 8'h00, 32'h0, 32'h0);
    chk("R10 low", {31'b0, fiq}, 32'h0);
    @(negedge clk); b1 = 32'h8000_0000; #1;
    chk("R10 not yet", {31'b0, fiq}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R10 after edge", {31'b0, fiq}, 32'h1);
    @(negedge clk); b1 = 32'h7fff_ffff; b0 = 8'hff; b2 = '1;
    @(posedge clk); @(negedge clk);
    chk("R10 other lines", {31'b0, fiq}, 32'h0);

    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      logic [2:0] pick = 3'($urandom_range(0, 7));
      a = (pick < 5) ? 8'h0c : ((pick == 5) ? 8'h08 : 8'h10);
      step(1'($urandom_range(0, 1)), a, $urandom(), 8'($urandom()), $urandom(), $urandom());
      check_all();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule